// File: doc/BRIEF.md
# Scrolled Tilemap Pixel Fetcher

This block turns one scrolling tile layer into a stream of palette color indices. It covers a visible window of `ACTIVE_W` by `ACTIVE_H` pixels, 496 by 384 by default. The layer is a 512 by 512 pixel plane of 8x8 tiles. A 64x64 table of 16-bit tile descriptors sits in external memory, and the block reads that memory through a 32-bit port with a fixed read latency. For each pixel the block does four things in order:

- It adds the vertical and horizontal scroll to the screen position, wrapping each axis on its own.
- It reads the descriptor of the tile under the result.
- It forms the address of that tile's pattern word and reads it.
- It extracts the pixel and joins it with the color bits held in the descriptor.

The horizontal scroll has two sources, picked by a bit in the scroll word. It can be one value for the whole layer, or a value per screen line read from a table in memory before that line starts. Pixels can be 4 bits or 8 bits deep.

A frame starts with a one-cycle pulse on `frame_go`. The block then scans the window in raster order and emits one valid pixel for each position. It holds a fetched pattern word for as long as successive pixels fall inside it.

Top module: `tile_pixel_fetch`

## Requirements
- R1: After reset `busy`, `pix_valid` and `vram_req` are low, and stay low until `frame_go` is pulsed.
- R2: A `frame_go` pulse while idle starts one scan of `ACTIVE_H` lines of `ACTIVE_W` pixels in raster order, with exactly one `pix_valid` cycle per pixel. A `frame_go` pulse while `busy` is high is ignored.
- R3: The fields of `scroll_cfg` are as follows. Bit 31 enables the layer. Bits 24:16 hold the vertical scroll. Bit 15 selects the per-line horizontal scroll. Bits 9:0 hold the horizontal scroll used when bit 15 is clear.
- R4: For screen position (x, y), the plane position is px = (x + hscroll) mod 512 and py = (y + vscroll) mod 512. Each axis wraps independently.
- R5: In per-line mode the horizontal scroll of screen line y is read from word `HTAB_BASE + y/2`. Even lines use bits 31:16 of that word and odd lines use bits 15:0.
- R6: The descriptor of the tile at (px, py) is in word `NAME_BASE + (py/8)*32 + px/16`. Even tile columns use bits 31:16 and odd tile columns use bits 15:0.
- R7: With `depth4` high, the pattern word address for descriptor d is {d[13:0], d[15], py[2:0]}. The pixel is nibble px[2:0] of that word, counted from bits 31:28. The color index is {d[14:4], nibble}.
- R8: With `depth4` low, the pattern word address is {d[13:0], py[2:0], px[2]}. The pixel is byte px[1:0] of that word, counted from bits 31:24. The color index is {d[14:8], byte}.
- R9: With the enable bit clear, every pixel has color index 0 and the block makes no memory reads.
- R10: Read data is taken from `vram_rdata` exactly `RD_LAT` clock edges after the edge at which `vram_req` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | One-cycle pulse that starts a frame scan |
| scroll_cfg | input | 32 | Layer enable, scroll values and line-mode select |
| depth4 | input | 1 | High for 4-bit pixels, low for 8-bit pixels |
| vram_req | output | 1 | Memory read request |
| vram_addr | output | 18 | Memory word address |
| vram_rdata | input | 32 | Memory read data, `RD_LAT` cycles after the request |
| busy | output | 1 | High while a frame scan is in progress |
| pix_valid | output | 1 | Pixel output strobe |
| pix_color | output | 15 | Palette color index of the pixel |

## Verification
Most internal faults show up as a wrong color index on the very pixel that uses the bad value. This covers a wrong scroll sum, a descriptor taken from the wrong half-word, a wrong pattern word address and a wrong shift. The fault is visible as soon as the pattern word is read, a few cycles after the pixel's turn. A stale held pattern word shows up at the first pixel after a word boundary. A fault in the line or column counters changes how many pixels a frame has, or how long `busy` stays high, by the end of that frame. The bench uses a memory whose contents are a function of the address, so that any misaddressed read produces a different color.

// File: rtl/tile_pixel_fetch.sv
module tile_pixel_fetch #(
  parameter int          ACTIVE_W  = 496,
  parameter int          ACTIVE_H  = 384,
  parameter int          RD_LAT    = 2,
  parameter logic [17:0] NAME_BASE = 18'h3E000,
  parameter logic [17:0] HTAB_BASE = 18'h3D800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_go,
  input  logic [31:0] scroll_cfg,
  input  logic        depth4,
  output logic        vram_req,
  output logic [17:0] vram_addr,
  input  logic [31:0] vram_rdata,
  output logic        busy,
  output logic        pix_valid,
  output logic [14:0] pix_color
);
  localparam int XW = $clog2(ACTIVE_W);
  localparam int YW = $clog2(ACTIVE_H);
  localparam int CW = $clog2(RD_LAT) + 1;

  typedef enum logic [2:0] {IDLE, LINE, HWAIT, PIX, NWAIT, PWAIT, EMIT} st_t;
  st_t st;

  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic [9:0]    hs;
  logic [15:0]   ent;
  logic [31:0]   patw;
  logic          fresh;
  logic [CW-1:0] cnt;

  wire       en   = scroll_cfg[31];
  wire [8:0] vs   = scroll_cfg[24:16];
  wire       lsel = scroll_cfg[15];

  wire [9:0] sumx = 10'(x) + hs;
  wire [8:0] px   = sumx[8:0];
  wire [8:0] py   = 9'(y) + vs;

  wire cap    = cnt == CW'(RD_LAT - 1);
  wire last_x = x == XW'(ACTIVE_W - 1);
  wire last_y = y == YW'(ACTIVE_H - 1);
  wire bound  = depth4 ? (px[2:0] == 3'd0) : (px[1:0] == 2'd0);

  wire [15:0] ent_now  = px[3] ? vram_rdata[15:0] : vram_rdata[31:16];
  wire [17:0] pat_addr = depth4 ? {ent_now[13:0], ent_now[15], py[2:0]}
                                : {ent_now[13:0], py[2:0], px[2]};
  wire [17:0] name_addr = NAME_BASE + 18'({py[8:3], px[8:4]});
  wire [17:0] htab_addr = HTAB_BASE + 18'(y >> 1);

  wire issue_line = (st == LINE) && en && lsel;
  wire fetch_pix  = (st == PIX) && en && (fresh || bound);
  wire issue_pat  = (st == NWAIT) && cap;
  wire emit       = ((st == PIX) && !fetch_pix) || (st == EMIT);

  wire [31:0] sh4 = patw << {px[2:0], 2'b00};
  wire [31:0] sh8 = patw << {px[1:0], 3'b000};
  wire [14:0] color = !en    ? 15'd0
                    : depth4 ? {ent[14:4], sh4[31:28]}
                             : {ent[14:8], sh8[31:24]};

  assign vram_req  = issue_line | fetch_pix | issue_pat;
  assign vram_addr = issue_line ? htab_addr : issue_pat ? pat_addr : name_addr;
  assign busy      = st != IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      x         <= '0;
      y         <= '0;
      hs        <= '0;
      ent       <= '0;
      patw      <= '0;
      fresh     <= 1'b1;
      cnt       <= '0;
      pix_valid <= 1'b0;
      pix_color <= '0;
    end else begin
      pix_valid <= emit;
      pix_color <= color;
      case (st)
        IDLE: if (frame_go) begin
          y  <= '0;
          st <= LINE;
        end
        LINE: begin
          x     <= '0;
          fresh <= 1'b1;
          cnt   <= '0;
          if (en && lsel) st <= HWAIT;
          else begin
            hs <= scroll_cfg[9:0];
            st <= PIX;
          end
        end
        HWAIT: if (cap) begin
          hs <= y[0] ? vram_rdata[9:0] : vram_rdata[25:16];
          st <= PIX;
        end else cnt <= cnt + CW'(1);
        NWAIT: if (cap) begin
          ent <= ent_now;
          cnt <= '0;
          st  <= PWAIT;
        end else cnt <= cnt + CW'(1);
        PWAIT: if (cap) begin
          patw  <= vram_rdata;
          fresh <= 1'b0;
          st    <= EMIT;
        end else cnt <= cnt + CW'(1);
        default: ;
      endcase
      if (fetch_pix) begin
        cnt <= '0;
        st  <= NWAIT;
      end else if (emit) begin
        if (!last_x) begin
          x  <= x + XW'(1);
          st <= PIX;
        end else if (last_y) st <= IDLE;
        else begin
          y  <= y + YW'(1);
          st <= LINE;
        end
      end
    end
  end
endmodule

// File: rtl/tile_pixel_fetch_chk.sv
module tile_pixel_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_go,
  input logic [31:0] scroll_cfg,
  input logic        vram_req,
  input logic        busy,
  input logic        pix_valid,
  input logic [14:0] pix_color
);
  // R1
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_req |-> busy);

  // R2
  start_needs_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_go));

  // R2
  valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(busy));

  // R9
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !$past(scroll_cfg[31])) |-> pix_color == 15'd0);
endmodule

bind tile_pixel_fetch tile_pixel_fetch_chk chk (
  .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .scroll_cfg(scroll_cfg),
  .vram_req(vram_req), .busy(busy), .pix_valid(pix_valid), .pix_color(pix_color)
);

// File: tb/tile_pixel_fetch_test.sv
module tile_pixel_fetch_test;
  localparam int W = 24;
  localparam int H = 5;
  localparam int NB = 18'h3E000;
  localparam int HB = 18'h3D800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_go = 1'b0;
  logic [31:0] scroll_cfg = '0;
  logic        depth4 = 1'b1;
  logic        vram_req;
  logic [17:0] vram_addr;
  logic [31:0] vram_rdata;
  logic        busy, pix_valid;
  logic [14:0] pix_color;

  int checks = 0, errors = 0, got = 0, reqs = 0;
  string tag = "R1";
  logic [14:0] expq[$];

  always #10 clk = ~clk;

  tile_pixel_fetch #(.ACTIVE_W(W), .ACTIVE_H(H), .RD_LAT(2),
                     .NAME_BASE(18'(NB)), .HTAB_BASE(18'(HB))) uut (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .scroll_cfg(scroll_cfg),
    .depth4(depth4), .vram_req(vram_req), .vram_addr(vram_addr),
    .vram_rdata(vram_rdata), .busy(busy), .pix_valid(pix_valid),
    .pix_color(pix_color));

  function automatic logic [31:0] vw(int a);
    logic [31:0] v = 32'(a);
    return (v * 32'h9E3779B1) ^ (v << 13) ^ 32'h5A5A1234;
  endfunction

  // memory with a two-edge read latency (R10)
  logic [17:0] a1;
  always @(posedge clk) begin
    a1 <= vram_addr;
    vram_rdata <= vw(int'(a1));
    if (vram_req) reqs++;
  end

  always @(negedge clk) if (rst_n && pix_valid) begin
    logic [14:0] e;
    checks++;
    got++;
    if (expq.size() == 0) begin
      errors++;
      $display("FAIL %s extra pixel got %h expected none", tag, pix_color);
    end else begin
      e = expq.pop_front();
      if (pix_color !== e) begin
        errors++;
        $display("FAIL %s pixel %0d got %h expected %h", tag, got - 1, pix_color, e);
      end
    end
  end

  function automatic logic [14:0] model(int x, int y, logic [31:0] cfg, logic d4);
    int hs, vs, px, py, pa;
    logic [31:0] t, nw, pw;
    logic [15:0] d;
    if (!cfg[31]) return 15'd0;
    vs = int'(cfg[24:16]);
    if (cfg[15]) begin
      t = vw(HB + y / 2);
      hs = (y % 2 == 0) ? int'(t[31:16]) : int'(t[15:0]);
    end else hs = int'(cfg[9:0]);
    px = (x + hs) % 512;
    py = (y + vs) % 512;
    nw = vw(NB + (py / 8) * 32 + px / 16);
    d = ((px / 8) % 2 == 0) ? nw[31:16] : nw[15:0];
    if (d4) begin
      pa = ((int'(d[13:0]) * 2 + int'(d[15])) * 8 + py % 8) % 262144;
      pw = vw(pa);
      return {d[14:4], 4'((pw >> (28 - 4 * (px % 8))) & 32'hF)};
    end
    pa = (int'(d[14:0]) * 16 + (py % 8) * 2 + (px % 8) / 4) % 262144;
    pw = vw(pa);
    return {d[14:8], 8'((pw >> (24 - 8 * (px % 4))) & 32'hFF)};
  endfunction

  function automatic logic [31:0] cfgw(bit en, int vs, bit ls, int hs);
    return {en, 6'd0, 9'(vs), ls, 5'd0, 10'(hs)};
  endfunction

  task automatic frame(logic [31:0] cfg, logic d4, string t, bit again);
    @(negedge clk);
    tag = t;
    scroll_cfg = cfg;
    depth4 = d4;
    got = 0;
    reqs = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) expq.push_back(model(x, y, cfg, d4));
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    if (again) begin
      repeat (30) @(negedge clk);
      frame_go = 1'b1;
      @(negedge clk);
      frame_go = 1'b0;
    end
    do @(negedge clk); while (busy);
    repeat (6) @(negedge clk);
    checks++;
    if (got != W * H || busy) begin
      errors++;
      $display("FAIL R2 %s pixel count got %0d expected %0d busy %0d", t, got, W * H, busy);
    end
    expq.delete();
    if (!cfg[31]) begin
      checks++;
      if (reqs != 0) begin
        errors++;
        $display("FAIL R9 reads while disabled got %0d expected 0", reqs);
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (busy || pix_valid || vram_req) begin
      errors++;
      $display("FAIL R1 reset busy/valid/req got %b%b%b expected 000", busy, pix_valid, vram_req);
    end
    frame(cfgw(1, 0, 0, 0), 1'b1, "R3 R6 R7 R10 zero scroll 4bpp", 0);
    frame(cfgw(1, 509, 0, 505), 1'b1, "R4 R7 wrap 4bpp", 0);
    frame(cfgw(1, 0, 0, 3), 1'b0, "R8 8bpp", 0);
    frame(cfgw(1, 510, 1, 0), 1'b0, "R5 R8 R4 line scroll 8bpp", 0);
    frame(cfgw(1, 7, 1, 100), 1'b1, "R5 R7 R2 line scroll with extra go", 1);
    frame(cfgw(0, 33, 1, 44), 1'b1, "R9 disabled", 0);
    frame(cfgw(1, 200, 0, 300), 1'b0, "R4 R8 mid plane", 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog expired got hung expected frame end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule